// File: doc/BRIEF.md
# IPL Sequence Controller

This block runs the processor end of the initial-program-load handshake on an I/O channel. A single-cycle load request starts a boot sequence. The controller raises the initiate-IPL line and a two-bit source-select status, which names the primary or alternate boot source as set by a selector switch at the moment of the request. In the same cycle it asserts the first system reset. It holds that reset for a minimum time, computed from the clock frequency, and then releases it.

After the reset is released, the controller waits for the device's IPL tag, which arrives asynchronously and passes through a synchroniser. Any tag seen before the reset has been asserted and released has no effect. A tag accepted after the release ends the sequence: initiate-IPL drops, the status returns to zero, and a one-cycle boot-accepted pulse is issued. If no tag arrives within a programmable number of cycles, the controller gives up. It then pulses an error output, drops initiate-IPL and goes back to idle.

Top module: `ipl_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `init_ipl`, `ipl_status`, `sys_reset`, `boot_accepted` and `timeout_err` are all 0.
- R2: A `load_key` pulse sampled while idle or finished makes `init_ipl` and `sys_reset` read 1 one clock later. In that same clock `ipl_status` reads 2'b01 (bit 0, primary) if `src_alt` was 0, or 2'b10 (bit 1, alternate) if `src_alt` was 1.
- R3: `sys_reset` stays high for exactly HOLD = ceil(RESET_MIN_NS * CLK_FREQ_HZ / 1e9) consecutive clocks. This is 1200 clocks at the defaults of 4800 ns and 250 MHz.
- R4: From assertion until the tag is accepted, `init_ipl` and `ipl_status` do not change, even when `src_alt` changes.
- R5: A tag that is high while `sys_reset` is asserted is ignored: `init_ipl` stays 1 and `boot_accepted` stays 0 for the whole reset hold.
- R6: Once `sys_reset` has been released, a rising `ipl_tag` is sampled by two synchroniser flops. `init_ipl` falls on the third clock edge after the tag rises, and `boot_accepted` is 1 for exactly that one clock.
- R7: Whenever `init_ipl` is 0, `ipl_status` is 2'b00.
- R8: If no tag is accepted within TIMEOUT_CYCLES clocks after `sys_reset` falls (2000 at the defaults), `timeout_err` is 1 for exactly one clock. In that clock `init_ipl` and `ipl_status` are 0, and `boot_accepted` stays 0.
- R9: A `load_key` pulse during an active sequence is ignored. The reset length and the status keep the values set by the first press.
- R10: A `load_key` pulse after a completed boot, or after a timeout, starts a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_key | input | 1 | One-cycle load request, already debounced |
| src_alt | input | 1 | Source switch: 0 primary, 1 alternate |
| ipl_tag | input | 1 | Asynchronous IPL tag from the device |
| init_ipl | output | 1 | Initiate-IPL line |
| ipl_status | output | 2 | Source select: bit 0 primary, bit 1 alternate |
| sys_reset | output | 1 | First system reset |
| boot_accepted | output | 1 | One-cycle pulse when the tag is accepted |
| timeout_err | output | 1 | One-cycle pulse when the tag wait expires |

## Verification
The bench measures the reset width to the exact cycle. A controller that is off by one, or that does not round up, reports a width other than 1200.

It holds the tag high for the whole reset phase. A controller that looks at the tag too early would end the sequence during the reset.

It sends a second load request and changes the switch in mid-sequence. A design that restarts the sequence or resamples the switch would then show a longer reset or a changed status.

It checks the timeout to the exact cycle, and it times tag acceptance edge by edge. A synchroniser with a missing or extra stage would move the point where `init_ipl` falls.

// File: rtl/ipl_seq_pkg.sv
package ipl_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE       = 2'd0,
    S_RESET_HOLD = 2'd1,
    S_WAIT_TAG   = 2'd2,
    S_DONE       = 2'd3
  } ipl_state_t;

  localparam logic [1:0] SEL_PRIMARY   = 2'b01;
  localparam logic [1:0] SEL_ALTERNATE = 2'b10;
  localparam logic [1:0] SEL_NONE      = 2'b00;

  // Minimum reset length in clocks, rounded up, never below one.
  function automatic int unsigned min_hold_cycles(input int unsigned freq_hz,
                                                  input int unsigned min_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(freq_hz) * longint'(min_ns);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ipl_tag_sync.sv
module ipl_tag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_async,
  output logic tag_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], tag_async};
  end

  assign tag_q = chain[STAGES-1];

endmodule

// File: rtl/ipl_down_timer.sv
module ipl_down_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (en && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_HOLDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R3

endmodule

// File: rtl/ipl_seq_ctrl.sv
module ipl_seq_ctrl
  import ipl_seq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ    = 250_000_000,
  parameter int unsigned RESET_MIN_NS   = 4800,
  parameter int unsigned TIMEOUT_CYCLES = 2000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_key,
  input  logic       src_alt,
  input  logic       ipl_tag,
  output logic       init_ipl,
  output logic [1:0] ipl_status,
  output logic       sys_reset,
  output logic       boot_accepted,
  output logic       timeout_err
);
  localparam int unsigned HOLD_CYC = min_hold_cycles(CLK_FREQ_HZ, RESET_MIN_NS);
  localparam int unsigned TO_CYC   = (TIMEOUT_CYCLES == 0) ? 1 : TIMEOUT_CYCLES;
  localparam int unsigned CNT_MAX  = max_u(HOLD_CYC, TO_CYC);
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LOAD   = CNT_W'(TO_CYC - 1);

  ipl_state_t state;
  logic       tag_q;
  logic       tmr_zero;

  // Named internal events
  logic press_ok, hold_done, tag_ok, wait_expired, tmr_load, tmr_en;
  logic [CNT_W-1:0] tmr_val;

  ipl_tag_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .tag_async(ipl_tag), .tag_q(tag_q)
  );

  assign press_ok     = load_key && (state == S_IDLE || state == S_DONE);
  assign hold_done    = (state == S_RESET_HOLD) && tmr_zero;
  assign tag_ok       = (state == S_WAIT_TAG) && tag_q;
  assign wait_expired = (state == S_WAIT_TAG) && !tag_q && tmr_zero;
  assign tmr_load     = press_ok || hold_done;
  assign tmr_val      = press_ok ? HOLD_LOAD : TO_LOAD;
  assign tmr_en       = (state == S_RESET_HOLD) || (state == S_WAIT_TAG);

  ipl_down_timer #(.W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .zero(tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      init_ipl      <= 1'b0;
      ipl_status    <= SEL_NONE;
      sys_reset     <= 1'b0;
      boot_accepted <= 1'b0;
      timeout_err   <= 1'b0;
    end else begin
      boot_accepted <= tag_ok;
      timeout_err   <= wait_expired;
      if (press_ok) begin
        state      <= S_RESET_HOLD;
        init_ipl   <= 1'b1;
        ipl_status <= src_alt ? SEL_ALTERNATE : SEL_PRIMARY;
        sys_reset  <= 1'b1;
      end else if (hold_done) begin
        state     <= S_WAIT_TAG;
        sys_reset <= 1'b0;
      end else if (tag_ok) begin
        state      <= S_DONE;
        init_ipl   <= 1'b0;
        ipl_status <= SEL_NONE;
      end else if (wait_expired) begin
        state      <= S_IDLE;
        init_ipl   <= 1'b0;
        ipl_status <= SEL_NONE;
      end
    end
  end

  AST_STATUS_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ipl |-> (ipl_status == SEL_NONE)); // R7
  AST_STATUS_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    init_ipl |-> ($countones(ipl_status) == 1)); // R2
  AST_RESET_WITHIN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> init_ipl); // R2
  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ipl && $past(init_ipl)) |-> $stable(ipl_status)); // R4
  AST_NO_ACCEPT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> !boot_accepted); // R5
  AST_ACCEPT_DROPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    boot_accepted |-> (!init_ipl && $past(init_ipl))); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err); // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_err && boot_accepted)); // R8

endmodule

// File: tb/test_ipl_seq_ctrl.sv
module test_ipl_seq_ctrl;

  localparam int EXP_HOLD = (4800 * 250 + 999) / 1000;
  localparam int EXP_TO   = 2000;

  typedef struct packed {
    logic       alt;
    logic [7:0] delay;
    logic       flip;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{alt: 1'b0, delay: 8'd0,  flip: 1'b0},
    '{alt: 1'b1, delay: 8'd5,  flip: 1'b0},
    '{alt: 1'b0, delay: 8'd17, flip: 1'b1},
    '{alt: 1'b1, delay: 8'd1,  flip: 1'b1},
    '{alt: 1'b1, delay: 8'd60, flip: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_key = 1'b0;
  logic src_alt = 1'b0;
  logic ipl_tag = 1'b0;
  logic init_ipl, sys_reset, boot_accepted, timeout_err;
  logic [1:0] ipl_status;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ipl_seq_ctrl i_ipl_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .load_key(load_key), .src_alt(src_alt),
    .ipl_tag(ipl_tag), .init_ipl(init_ipl), .ipl_status(ipl_status),
    .sys_reset(sys_reset), .boot_accepted(boot_accepted), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input logic alt);
    src_alt  = alt;
    load_key = 1'b1;
    step();
    load_key = 1'b0;
  endtask

  // Count the clocks sys_reset is high, starting at the first high sample.
  task automatic measure_hold(output int n);
    n = 0;
    while (sys_reset && n < 5000) begin
      n++;
      step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [1:0] exp_st;

    step(3);
    chk({init_ipl, ipl_status, sys_reset, boot_accepted, timeout_err} == 6'b0,
        "R1", "outputs in reset", {init_ipl, ipl_status, sys_reset, boot_accepted, timeout_err}, 0);
    rst_n = 1'b1;
    step();
    chk({init_ipl, ipl_status, sys_reset, boot_accepted, timeout_err} == 6'b0,
        "R1", "outputs after reset", {init_ipl, ipl_status, sys_reset, boot_accepted, timeout_err}, 0);

    // Vector table: full sequences, each after the first restarting from DONE (R10)
    foreach (VECS[k]) begin
      exp_st = VECS[k].alt ? 2'b10 : 2'b01;
      press(VECS[k].alt);
      chk(init_ipl && sys_reset, "R2", "init and reset together", {init_ipl, sys_reset}, 3);
      chk(ipl_status == exp_st, "R2", "status from switch", ipl_status, exp_st);
      measure_hold(n);
      chk(n == EXP_HOLD, "R3", "reset width", n, EXP_HOLD);
      if (VECS[k].flip) src_alt = ~src_alt;
      step(VECS[k].delay);
      chk(init_ipl && ipl_status == exp_st, "R4", "held while waiting", ipl_status, exp_st);
      ipl_tag = 1'b1;
      step(2);
      chk(init_ipl == 1'b1 && !boot_accepted, "R6", "still high after two edges", init_ipl, 1);
      step();
      chk(!init_ipl && boot_accepted, "R6", "dropped on third edge", {init_ipl, boot_accepted}, 1);
      chk(ipl_status == 2'b00, "R7", "status cleared", ipl_status, 0);
      step();
      chk(!boot_accepted, "R6", "accept pulse one cycle", boot_accepted, 0);
      ipl_tag = 1'b0;
      step(4);
      if (k > 0) chk(!init_ipl && !timeout_err, "R10", "done state after restart", init_ipl, 0);
    end

    // Tag held high across the reset phase
    ipl_tag = 1'b1;
    step(4);
    press(1'b0);
    n = 0;
    begin
      int bad = 0;
      while (sys_reset && n < 5000) begin
        if (!init_ipl || boot_accepted) bad++;
        n++;
        step();
      end
      chk(bad == 0, "R5", "early tag ignored during hold", bad, 0);
    end
    chk(n == EXP_HOLD, "R5", "hold not cut short by tag", n, EXP_HOLD);
    step();
    chk(boot_accepted && !init_ipl, "R5", "tag accepted right after release", boot_accepted, 1);
    ipl_tag = 1'b0;
    step(4);

    // Second press in the middle of the hold
    press(1'b0);
    step(EXP_HOLD / 2 - 1);
    press(1'b1);
    chk(ipl_status == 2'b01, "R9", "status kept after second press", ipl_status, 1);
    begin
      int rest;
      measure_hold(rest);
      chk(rest + EXP_HOLD / 2 == EXP_HOLD, "R9", "reset width unchanged", rest + EXP_HOLD / 2, EXP_HOLD);
    end

    // Timeout from here
    n = 0;
    while (!timeout_err && n < 5000) begin
      step();
      n++;
    end
    chk(n == EXP_TO, "R8", "timeout delay", n, EXP_TO);
    chk(!init_ipl && ipl_status == 2'b00 && !boot_accepted, "R8", "outputs on timeout",
        {init_ipl, ipl_status, boot_accepted}, 0);
    step();
    chk(!timeout_err, "R8", "error pulse one cycle", timeout_err, 0);

    // Restart after timeout
    press(1'b1);
    chk(init_ipl && sys_reset && ipl_status == 2'b10, "R10", "restart after timeout",
        {init_ipl, sys_reset, ipl_status}, 6'b1110 >> 0);

    // Asynchronous reset mid-sequence
    step(10);
    rst_n = 1'b0;
    step();
    chk({init_ipl, ipl_status, sys_reset} == 4'b0, "R1", "reset clears active sequence",
        {init_ipl, ipl_status, sys_reset}, 0);
    rst_n = 1'b1;
    step(2);
    chk(!init_ipl && ipl_status == 2'b00, "R7", "idle status zero", ipl_status, 0);

    summary();
    $finish;
  end

endmodule